// File: doc/BRIEF.md
# Converter Channel Scan Sequencer

This block is the control logic that sits beside a successive-approximation converter serving twelve analog inputs. It selects the input to convert, pulses a start strobe to the converter core and then waits for the core's done pulse. The returned sample goes into a result register that belongs to that input. The core itself lies outside the block. The only contact with it is the start strobe, the channel select, the diagnostic reference select, the done pulse and the result bus.

Three operating modes exist. Single mode converts one chosen input once. One-pass scan covers every enabled input of a mask once, lowest index first, and then stops. Continuous scan repeats those passes until software stops it. A run can be started by a software go pulse, by a timer pulse or by a rising edge on an external trigger pin, and a select field chooses which hardware source is honoured. Results can be stored at full width or cut to 8 significant bits. A diagnostic setting makes the core sample an internal level in place of the pin.

The converter core cannot stall a result, so the block has no valid/ready stream interface. The done pulse is taken as-is. Results are held in registers and can be read at any time through a combinational read port, which has no back-pressure.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `run`, `irq`, `scan_flag` and `conv_start` are 0, and every result register reads 0.
- R2: Single mode (`cfg_mode`=0) converts input `cfg_chan` exactly once and stores the sample in that input's register. `run` then returns to 0 and `irq` pulses.
- R3: One-pass scan (`cfg_mode`=1 or 3) converts each input whose `cfg_scan_mask` bit is set exactly once, in ascending index order starting at the lowest set bit. It then pulses `irq` once and drops `run`.
- R4: Continuous scan (`cfg_mode`=2) starts the next pass from the lowest enabled input. The first `conv_start` of that pass is in the same cycle as the end-of-pass `irq` pulse, and passes repeat until `sw_stop` returns the block to idle.
- R5: `conv_start` is high for exactly one cycle per conversion. `conv_sel` holds the converted input from the start strobe until the done pulse.
- R6: `sw_go` always starts a run. `tmr_trig` starts a run only when `cfg_trig_sel`=1, and a rising edge on `ext_trig` starts a run only when `cfg_trig_sel`=2. A level held high on `ext_trig` does not start a second run.
- R7: Any trigger that arrives while `run` is 1 is ignored. The run in progress makes no extra conversion and no extra pass.
- R8: With `cfg_fmt8`=1 the stored value is the 10-bit sample shifted right by two, with the upper two bits zero.
- R9: `conv_diag_en` and `conv_diag_lvl` pass the diagnostic setting to the core: level 0 is analog ground, 1 is half reference and 2 is full reference. The sampled level is stored in the register of the selected input.
- R10: A trigger is ignored when scan mode has an empty mask or single mode names an input of 12 or more.
- R11: `irq` is a one-cycle pulse at the end of every pass or single conversion. `scan_flag` is set in the same cycle and stays set until `flag_clr`. A set in the same cycle as `flag_clr` wins.
- R12: A done pulse that arrives while no conversion is outstanding writes nothing. Registers of inputs that are not converted keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 single, 1 one-pass scan, 2 continuous scan, 3 one-pass scan |
| cfg_chan | input | 4 | Input converted in single mode |
| cfg_scan_mask | input | 12 | Inputs enabled in scan modes |
| cfg_trig_sel | input | 2 | Hardware trigger: 1 timer, 2 external pin, other none |
| cfg_fmt8 | input | 1 | Store the sample shifted right by two |
| cfg_diag_en | input | 1 | Route an internal level to the core |
| cfg_diag_lvl | input | 2 | Internal level: 0 ground, 1 half, 2 full |
| sw_go | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse, aborts any run |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External trigger pin, rising edge |
| flag_clr | input | 1 | Clears scan_flag |
| conv_start | output | 1 | One-cycle start strobe to the core |
| conv_sel | output | 4 | Input selected for the core |
| conv_diag_en | output | 1 | Diagnostic routing to the core |
| conv_diag_lvl | output | 2 | Diagnostic level to the core |
| conv_done | input | 1 | Core done pulse, one cycle |
| conv_data | input | 10 | Core sample, valid with conv_done |
| rd_idx | input | 4 | Result register index to read |
| rd_data | output | 10 | Result register contents, combinational |
| run | output | 1 | Start bit: a run is in progress |
| scan_flag | output | 1 | Sticky end-of-pass flag |
| irq | output | 1 | End-of-pass pulse |

## Verification
When a trigger is accepted at a clock edge, `run` rises and `conv_start` is high for the cycle after that edge. The result register changes at the edge after the done pulse. `irq`, `scan_flag` and the fall of `run` all appear at the same edge as the write of the last conversion of a pass. The bench drives inputs and samples every output on the falling edge, so each result is read half a cycle after the edge that made it. The bench waits for `run` to fall and then for more than the core latency before it reads registers or logs. Its core model delays each done pulse by a fixed number of cycles after the strobe, and the bench compares the logged strobe order and counts against lists it builds from the mask.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_ONEPASS = 2'd1,
    MODE_CONT    = 2'd2
  } seq_mode_e;

  typedef enum logic [1:0] {
    TRG_NONE = 2'd0,
    TRG_TMR  = 2'd1,
    TRG_EXT  = 2'd2
  } trig_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       sw_go,
  input  logic       tmr_trig,
  input  logic       ext_pin,
  output logic       hit
);
  logic ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_pin;
  end

  always_comb begin
    hit = sw_go;
    if (src_sel == TRG_TMR && tmr_trig)          hit = 1'b1;
    if (src_sel == TRG_EXT && ext_pin && !ext_q) hit = 1'b1;
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int N_CH = 12,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask,
  input  logic            from_base,
  input  logic [CH_W-1:0] after,
  output logic            found,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask[i] && (from_base || CH_W'(i) > after)) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_CH  = 12,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic             fmt8,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [RES_W-1:0] rd_data
);
  localparam int SHIFT = RES_W - 8;

  logic [RES_W-1:0] regs [N_CH];
  logic [RES_W-1:0] wr_val;

  assign wr_val = fmt8 ? (wr_data >> SHIFT) : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_CH; i++)
        if (wr_idx == CH_W'(i)) regs[i] <= wr_val;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_idx == CH_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int N_CH  = 12,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [N_CH-1:0]  cfg_scan_mask,
  input  logic [1:0]       cfg_trig_sel,
  input  logic             cfg_fmt8,
  input  logic             cfg_diag_en,
  input  logic [1:0]       cfg_diag_lvl,
  input  logic             sw_go,
  input  logic             sw_stop,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  input  logic             flag_clr,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_sel,
  output logic             conv_diag_en,
  output logic [1:0]       conv_diag_lvl,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [RES_W-1:0] rd_data,
  output logic             run,
  output logic             scan_flag,
  output logic             irq
);
  seq_state_e      state;
  logic [CH_W-1:0] cur;
  logic            hit, start_ok, is_single, is_cont;
  logic            first_found, next_found;
  logic [CH_W-1:0] first_idx, next_idx;
  logic            wr_en;

  assign is_single = (cfg_mode == MODE_SINGLE);
  assign is_cont   = (cfg_mode == MODE_CONT);
  assign start_ok  = is_single ? (cfg_chan < CH_W'(N_CH)) : first_found;

  adc_trig_sel u_trig (
    .clk(clk), .rst_n(rst_n), .src_sel(cfg_trig_sel), .sw_go(sw_go),
    .tmr_trig(tmr_trig), .ext_pin(ext_trig), .hit(hit)
  );

  adc_chan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_first (
    .mask(cfg_scan_mask), .from_base(1'b1), .after('0),
    .found(first_found), .idx(first_idx)
  );

  adc_chan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_next (
    .mask(cfg_scan_mask), .from_base(1'b0), .after(cur),
    .found(next_found), .idx(next_idx)
  );

  assign wr_en = (state == ST_WAIT) && conv_done;

  adc_result_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cur), .wr_data(conv_data),
    .fmt8(cfg_fmt8), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      irq       <= 1'b0;
      scan_flag <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (flag_clr) scan_flag <= 1'b0;
      if (sw_stop) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (hit && start_ok) begin
              cur   <= is_single ? cfg_chan : first_idx;
              state <= ST_ISSUE;
            end
          end
          ST_ISSUE: state <= ST_WAIT;
          ST_WAIT: begin
            if (conv_done) begin
              if (!is_single && next_found) begin
                cur   <= next_idx;
                state <= ST_ISSUE;
              end else begin
                irq       <= 1'b1;
                scan_flag <= 1'b1;
                if (is_cont && first_found) begin
                  cur   <= first_idx;
                  state <= ST_ISSUE;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign run           = (state != ST_IDLE);
  assign conv_start    = (state == ST_ISSUE);
  assign conv_sel      = cur;
  assign conv_diag_en  = cfg_diag_en;
  assign conv_diag_lvl = cfg_diag_lvl;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int N_CH = 12,
  parameter int CH_W = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic [N_CH-1:0] cfg_scan_mask,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_sel,
  input logic            run,
  input logic            irq,
  input logic            scan_flag
);
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r5_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> $stable(conv_sel));

  a_r3_sel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && cfg_mode != 2'd0) |-> cfg_scan_mask[conv_sel]);

  a_r10_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> run);

  a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r11_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scan_flag);

  a_r2_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_mode != 2'd2) |-> !run);

  a_r4_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_mode == 2'd2 && cfg_scan_mask != '0) |-> conv_start);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_scan_mask(cfg_scan_mask),
  .conv_start(conv_start), .conv_sel(conv_sel), .run(run), .irq(irq),
  .scan_flag(scan_flag)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int N_CH = 12;
  localparam int CH_W = 4;
  localparam int RES_W = 10;
  localparam int LAT = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] cfg_mode, cfg_trig_sel, cfg_diag_lvl;
  logic [CH_W-1:0] cfg_chan, rd_idx;
  logic [N_CH-1:0] cfg_scan_mask;
  logic cfg_fmt8, cfg_diag_en, sw_go, sw_stop, tmr_trig, ext_trig, flag_clr;
  logic conv_start, conv_diag_en, conv_done, run, scan_flag, irq;
  logic [CH_W-1:0] conv_sel;
  logic [1:0] conv_diag_lvl;
  logic [RES_W-1:0] conv_data, rd_data;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_scan_mask(cfg_scan_mask), .cfg_trig_sel(cfg_trig_sel), .cfg_fmt8(cfg_fmt8),
    .cfg_diag_en(cfg_diag_en), .cfg_diag_lvl(cfg_diag_lvl), .sw_go(sw_go),
    .sw_stop(sw_stop), .tmr_trig(tmr_trig), .ext_trig(ext_trig), .flag_clr(flag_clr),
    .conv_start(conv_start), .conv_sel(conv_sel), .conv_diag_en(conv_diag_en),
    .conv_diag_lvl(conv_diag_lvl), .conv_done(conv_done), .conv_data(conv_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .run(run), .scan_flag(scan_flag), .irq(irq)
  );

  // Converter core stand-in: done pulse LAT cycles after the strobe.
  logic mdl_busy = 1'b0, mdl_done = 1'b0, inj_done = 1'b0;
  int mdl_cnt = 0, conv_total = 0;
  logic [RES_W-1:0] mdl_val = '0;

  function automatic logic [RES_W-1:0] sample_of(input int sel, input logic den,
                                                 input logic [1:0] lvl, input int n);
    if (den) return (lvl == 2'd1) ? 10'h200 : (lvl == 2'd2) ? 10'h3FF : 10'h000;
    return RES_W'(sel * 67 + n * 29 + 5);
  endfunction

  always @(posedge clk) begin
    mdl_done <= 1'b0;
    if (conv_start) begin
      mdl_busy   <= 1'b1;
      mdl_cnt    <= LAT;
      mdl_val    <= sample_of(int'(conv_sel), conv_diag_en, conv_diag_lvl, conv_total);
      conv_total <= conv_total + 1;
    end else if (mdl_busy) begin
      if (mdl_cnt == 1) begin
        mdl_busy <= 1'b0;
        mdl_done <= 1'b1;
      end
      mdl_cnt <= mdl_cnt - 1;
    end
  end

  assign conv_done = mdl_done | inj_done;
  assign conv_data = inj_done ? 10'h155 : mdl_val;

  // Observation at the falling edge.
  int log_sel [64];
  int log_n = 0, irq_n = 0, restart_ok = 0;
  logic [RES_W-1:0] exp_reg [N_CH];

  always @(negedge clk) begin
    if (conv_start) begin
      if (log_n < 64) log_sel[log_n] = int'(conv_sel);
      log_n++;
    end
    if (irq) begin
      irq_n++;
      if (cfg_mode == 2'd2 && conv_start) restart_ok++;
    end
    if (conv_done && run)
      exp_reg[conv_sel] = cfg_fmt8 ? {2'b00, conv_data[9:2]} : conv_data;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; irq_n = 0; restart_ok = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk) sw_go = 1'b1;
    @(negedge clk) sw_go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (run && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int ch = 0; ch < N_CH; ch++) begin
      rd_idx = CH_W'(ch);
      #1;
      chk(rd_data == exp_reg[ch], req, int'(rd_data), int'(exp_reg[ch]));
    end
    @(negedge clk);
  endtask

  task automatic scan_once(input logic [N_CH-1:0] mask, input logic [1:0] mode);
    int exp_list [N_CH];
    int exp_n = 0;
    for (int i = 0; i < N_CH; i++)
      if (mask[i]) begin exp_list[exp_n] = i; exp_n++; end
    cfg_mode = mode; cfg_scan_mask = mask;
    clear_log();
    pulse_go();
    wait_idle();
    chk(log_n == exp_n, "R3 conversion count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < 64; k++)
      chk(log_sel[k] == exp_list[k], "R3 ascending order", log_sel[k], exp_list[k]);
    chk(irq_n == 1, "R3 one irq per pass", irq_n, 1);
    chk(run == 1'b0, "R3 run cleared", int'(run), 0);
    check_regs("R12 registers after scan");
  endtask

  initial begin
    int saved;
    for (int i = 0; i < N_CH; i++) exp_reg[i] = '0;
    rst_n = 1'b0;
    cfg_mode = 2'd0; cfg_chan = '0; cfg_scan_mask = '0; cfg_trig_sel = 2'd0;
    cfg_fmt8 = 1'b0; cfg_diag_en = 1'b0; cfg_diag_lvl = 2'd0;
    sw_go = 0; sw_stop = 0; tmr_trig = 0; ext_trig = 0; flag_clr = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(run == 0 && irq == 0 && scan_flag == 0 && conv_start == 0,
        "R1 reset outputs", int'({run, irq, scan_flag, conv_start}), 0);
    check_regs("R1 reset registers");

    // R2 and R8: single mode over every input, both formats
    for (int f = 0; f < 2; f++) begin
      for (int ch = 0; ch < N_CH; ch++) begin
        cfg_mode = 2'd0; cfg_chan = CH_W'(ch); cfg_fmt8 = f[0];
        clear_log();
        pulse_go();
        wait_idle();
        chk(log_n == 1, "R2 single count", log_n, 1);
        chk(log_sel[0] == ch, "R2 single input", log_sel[0], ch);
        chk(irq_n == 1, "R2 single irq", irq_n, 1);
        chk(run == 0, "R2 start bit clears", int'(run), 0);
      end
      check_regs(f == 0 ? "R2 full-width results" : "R8 shifted results");
    end
    cfg_fmt8 = 1'b0;

    // R11 sticky flag and clear
    chk(scan_flag == 1, "R11 flag sticky", int'(scan_flag), 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk(scan_flag == 0, "R11 flag cleared", int'(scan_flag), 0);

    // R3 one-pass scans over several masks
    scan_once(12'hFFF, 2'd1);
    scan_once(12'h801, 2'd1);
    scan_once(12'h0A4, 2'd3);
    scan_once(12'h010, 2'd1);
    scan_once(12'h555, 2'd1);

    // R4 continuous scan
    cfg_mode = 2'd2; cfg_scan_mask = 12'h00C;
    clear_log();
    pulse_go();
    begin
      int n = 0;
      while (irq_n < 3 && n < 2000) begin @(negedge clk); n++; end
    end
    chk(run == 1, "R4 still running", int'(run), 1);
    @(negedge clk) sw_stop = 1'b1;
    @(negedge clk) sw_stop = 1'b0;
    chk(run == 0, "R4 stop returns idle", int'(run), 0);
    repeat (LAT + 3) @(negedge clk);
    chk(restart_ok == 3, "R4 restart with irq", restart_ok, 3);
    for (int k = 0; k < 6; k++)
      chk(log_sel[k] == ((k % 2) + 2), "R4 pass order", log_sel[k], (k % 2) + 2);
    check_regs("R4 results");

    // R6 trigger source selection
    cfg_mode = 2'd0; cfg_chan = 4'd7; cfg_trig_sel = 2'd1;
    clear_log();
    @(negedge clk) ext_trig = 1'b1;
    @(negedge clk) ext_trig = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 0, "R6 ext ignored under timer select", log_n, 0);
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    wait_idle();
    chk(log_n == 1, "R6 timer starts", log_n, 1);
    cfg_trig_sel = 2'd2;
    clear_log();
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 0, "R6 timer ignored under ext select", log_n, 0);
    @(negedge clk) ext_trig = 1'b1;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(log_n == 1, "R6 ext edge starts once", log_n, 1);
    ext_trig = 1'b0;
    cfg_trig_sel = 2'd0;
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 1, "R6 timer ignored with no hw select", log_n, 1);

    // R7 triggers while busy
    cfg_mode = 2'd1; cfg_scan_mask = 12'h0F0; cfg_trig_sel = 2'd1;
    clear_log();
    pulse_go();
    @(negedge clk) begin sw_go = 1'b1; tmr_trig = 1'b1; end
    @(negedge clk) begin sw_go = 1'b0; tmr_trig = 1'b0; end
    wait_idle();
    chk(log_n == 4, "R7 no extra conversions", log_n, 4);
    chk(irq_n == 1, "R7 no extra pass", irq_n, 1);
    cfg_trig_sel = 2'd0;

    // R9 diagnostic levels with both formats
    cfg_mode = 2'd0; cfg_diag_en = 1'b1; cfg_diag_lvl = 2'd2; cfg_chan = 4'd9;
    #1;
    chk(conv_diag_en == 1 && conv_diag_lvl == 2'd2, "R9 diag routing",
        int'(conv_diag_lvl), 2);
    pulse_go();
    wait_idle();
    rd_idx = 4'd9; #1;
    chk(rd_data == 10'h3FF, "R9 full reference", int'(rd_data), 'h3FF);
    cfg_diag_lvl = 2'd1; cfg_chan = 4'd0; cfg_fmt8 = 1'b1;
    pulse_go();
    wait_idle();
    rd_idx = 4'd0; #1;
    chk(rd_data == 10'h080, "R9 half reference shifted", int'(rd_data), 'h080);
    cfg_diag_lvl = 2'd0; cfg_chan = 4'd3; cfg_fmt8 = 1'b0;
    pulse_go();
    wait_idle();
    rd_idx = 4'd3; #1;
    chk(rd_data == 10'h000, "R9 ground", int'(rd_data), 0);
    cfg_diag_en = 1'b0;
    check_regs("R9 other registers");

    // R10 triggers with nothing to convert
    cfg_mode = 2'd1; cfg_scan_mask = '0;
    clear_log();
    pulse_go();
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 0 && run == 0, "R10 empty mask ignored", log_n, 0);
    cfg_mode = 2'd0; cfg_chan = 4'd12;
    pulse_go();
    repeat (LAT + 3) @(negedge clk);
    chk(log_n == 0 && run == 0, "R10 out-of-range input ignored", log_n, 0);

    // R12 stray done pulse while idle
    saved = 0;
    @(negedge clk) inj_done = 1'b1;
    @(negedge clk) inj_done = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R12 stray done ignored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule